// File: doc/BRIEF.md
# Gated Power-of-Two Strobe Divider Bank

This block turns a small set of shared source strobes into up to sixteen independent divided strobes, all in a single system clock domain. Each channel picks one of four source strobes, counts its pulses, and emits a one-cycle output strobe every 1, 2, 4 or 8 selected pulses. Any channel can be held off with a disable bit. Downstream logic uses the channel strobes as clock enables.

Software programs the bank through a 32-bit register port with three words: one for disables, one for source choice and one for the division ratio. Fields for all channels are packed side by side in these shared words. A new source choice or ratio is only adopted on a channel's own divided boundary, so a reprogrammed channel never emits a shortened period. Releasing a disabled channel starts its count from zero.

Top module: `clk_strobe_bank`

## Requirements
- R1: After reset every channel is disabled (disable word reads 0x0000FFFF), the source and ratio words read 0, and no channel strobe is asserted.
- R2: The disable word is at byte offset 0x0 with bit i for channel i; a 1 holds the channel off so it emits no strobe, and a 0 lets it run.
- R3: The source word is at offset 0x4; bits 2i+1:2i of it give the index (0 to 3) of the source strobe that channel i counts.
- R4: The ratio word is at offset 0x8; bits 2i+1:2i of it hold a code k for channel i, and the channel emits one strobe per 2^k selected source pulses (codes 0, 1, 2, 3 give 1, 2, 4, 8).
- R5: When a channel is released from disable its count restarts, so its first strobe comes on the 2^k-th selected source pulse after release.
- R6: A write to a running channel's source or ratio field is adopted only when that channel completes its current divided period; while disabled a channel follows its fields at once.
- R7: Reads return the stored words, bits above the channel count in the disable word read 0, offsets other than 0x0, 0x4 and 0x8 read 0, and writes to them change nothing.
- R8: A channel strobe is one cycle wide and appears in the cycle after the clock edge that samples the terminal source pulse.
- R9: Channels are independent: programming or pulses that concern one channel do not alter the strobes of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| src_tick | input | 4 | Shared source strobes, one per source index |
| ch_tick | output | 16 | Divided strobe per channel |

## Verification
On every cycle the assertions hold that a disabled channel stays silent, that a running channel's adopted source and ratio stay put between boundaries, that the period counter never passes the terminal count of its ratio, that each strobe follows a counted source pulse, and that writes land in or bypass the register words as decoded. Whether a strobe arrives in exactly the right cycle, whether release restarts the count, whether a mid-period ratio change waits for the boundary, and whether channels stay independent under mixed source traffic can only be shown by the bench's scenarios, which compare every strobe of all channels against an independent cycle model.

// File: rtl/csb_pkg.sv
package csb_pkg;

  // Byte offsets of the three programming words
  localparam int unsigned OFS_DISABLE = 32'h0;
  localparam int unsigned OFS_SOURCE  = 32'h4;
  localparam int unsigned OFS_RATIO   = 32'h8;

  // Number of source pulses per output strobe for a ratio code
  function automatic int unsigned ratio_of(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Terminal value of the period counter for a ratio code
  function automatic int unsigned last_count(input int unsigned code);
    return ratio_of(code) - 32'd1;
  endfunction

endpackage

// File: rtl/csb_regs.sv
module csb_regs #(
  parameter int NUM_CH = 16,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic [NUM_CH-1:0]       disable_o,
  output logic [NUM_CH*SEL_W-1:0] source_o,
  output logic [NUM_CH*DIV_W-1:0] ratio_o
);
  import csb_pkg::*;

  localparam int SRC_BITS = NUM_CH * SEL_W;
  localparam int RAT_BITS = NUM_CH * DIV_W;

  logic [NUM_CH-1:0]   dis_q;
  logic [SRC_BITS-1:0] src_q;
  logic [RAT_BITS-1:0] rat_q;

  // Decoded register hits, brought out for the checks below
  logic hit_dis, hit_src, hit_rat, hit_none;
  assign hit_dis  = (addr == ADDR_W'(OFS_DISABLE));
  assign hit_src  = (addr == ADDR_W'(OFS_SOURCE));
  assign hit_rat  = (addr == ADDR_W'(OFS_RATIO));
  assign hit_none = !(hit_dis || hit_src || hit_rat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= '1;
      src_q <= '0;
      rat_q <= '0;
    end else if (wr_en) begin
      if (hit_dis) dis_q <= wdata[NUM_CH-1:0];
      if (hit_src) src_q <= wdata[SRC_BITS-1:0];
      if (hit_rat) rat_q <= wdata[RAT_BITS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_dis) rdata = DATA_W'(dis_q);
    if (hit_src) rdata = DATA_W'(src_q);
    if (hit_rat) rdata = DATA_W'(rat_q);
  end

  assign disable_o = dis_q;
  assign source_o  = src_q;
  assign ratio_o   = rat_q;

  // R2
  dis_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_dis) |=> (disable_o == $past(wdata[NUM_CH-1:0])));

  // R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_none) |=> ($stable(disable_o) && $stable(source_o) && $stable(ratio_o)));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |-> (rdata == '0));

endmodule

// File: rtl/csb_channel.sv
module csb_channel #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disable_i,
  input  logic [SEL_W-1:0]      source_i,
  input  logic [DIV_W-1:0]      ratio_i,
  input  logic [(1<<SEL_W)-1:0] src_i,
  output logic                  tick_o
);
  import csb_pkg::*;

  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [SEL_W-1:0] act_src;
  logic [DIV_W-1:0] act_rat;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_last;

  // Named internal events
  logic src_hit;
  logic at_last;
  logic boundary;

  assign cnt_last = CNT_W'(last_count(32'(act_rat)));
  assign src_hit  = src_i[act_src];
  assign at_last  = (cnt == cnt_last);
  assign boundary = !disable_i && src_hit && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_src <= '0;
      act_rat <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= boundary;
      if (disable_i) begin
        cnt     <= '0;
        act_src <= source_i;
        act_rat <= ratio_i;
      end else if (src_hit) begin
        if (at_last) begin
          cnt     <= '0;
          act_src <= source_i;
          act_rat <= ratio_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !tick_o);

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disable_i && !boundary) |=> ($stable(act_src) && $stable(act_rat)));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (cnt <= cnt_last));

  // R8
  tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> tick_o);

  // R5
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (cnt == '0));

endmodule

// File: rtl/clk_strobe_bank.sv
module clk_strobe_bank #(
  parameter int NUM_CH = 16,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [(1<<SEL_W)-1:0] src_tick,
  output logic [NUM_CH-1:0]     ch_tick
);

  localparam int SRC_BITS = NUM_CH * SEL_W;
  localparam int RAT_BITS = NUM_CH * DIV_W;

  logic [NUM_CH-1:0]   dis_bus;
  logic [SRC_BITS-1:0] src_bus;
  logic [RAT_BITS-1:0] rat_bus;

  csb_regs #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .DIV_W  (DIV_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .disable_o (dis_bus),
    .source_o  (src_bus),
    .ratio_o   (rat_bus)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    csb_channel #(
      .SEL_W (SEL_W),
      .DIV_W (DIV_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .disable_i (dis_bus[i]),
      .source_i  (src_bus[i*SEL_W +: SEL_W]),
      .ratio_i   (rat_bus[i*DIV_W +: DIV_W]),
      .src_i     (src_tick),
      .tick_o    (ch_tick[i])
    );
  end

  // R1
  idle_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_bus == '1) |=> (ch_tick == '0));

endmodule

// File: tb/clk_strobe_bank_tb.sv
`timescale 1ns/1ps
module clk_strobe_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  src_tick = '0;
  logic [15:0] ch_tick;

  always #2 clk = ~clk;

  clk_strobe_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_tick  (src_tick),
    .ch_tick   (ch_tick)
  );

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";
  logic [15:0] exp_q[$];

  // Independent behavioural model of the bank
  logic [15:0] m_dis = 16'hFFFF;
  logic [31:0] m_src = '0;
  logic [31:0] m_rat = '0;
  int a_src[16];
  int a_rat[16];
  int seen[16];

  initial for (int c = 0; c < 16; c++) begin a_src[c] = 0; a_rat[c] = 0; seen[c] = 0; end

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return {16'h0, m_dis};
      4'h4: return m_src;
      4'h8: return m_rat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(input logic we, input logic [3:0] a,
                            input logic [31:0] d, input logic [3:0] s);
    logic [15:0] e = '0;
    for (int c = 0; c < 16; c++) begin
      if (m_dis[c]) begin
        seen[c] = 0;
        a_src[c] = int'(m_src[2*c +: 2]);
        a_rat[c] = int'(m_rat[2*c +: 2]);
      end else if (s[a_src[c]]) begin
        seen[c] = seen[c] + 1;
        if (seen[c] == (1 << a_rat[c])) begin
          e[c] = 1'b1;
          seen[c] = 0;
          a_src[c] = int'(m_src[2*c +: 2]);
          a_rat[c] = int'(m_rat[2*c +: 2]);
        end
      end
    end
    if (we) begin
      if (a == 4'h0) m_dis = d[15:0];
      if (a == 4'h4) m_src = d;
      if (a == 4'h8) m_rat = d;
    end
    exp_q.push_back(e);
  endtask

  // Driver: one clock cycle of stimulus, expected result pushed to scoreboard
  task automatic cycle(input logic we, input logic [3:0] a,
                       input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; src_tick = s;
    model_step(we, a, d, s);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    cycle(1'b1, a, d, s);
  endtask

  task automatic rd_check(input logic [3:0] a, input string why);
    logic [31:0] e;
    cycle(1'b0, a, 32'h0, 4'h0);
    e = exp_read(a);
    #1;
    vectors++;
    if (reg_rdata !== e) begin
      miscompares++;
      $display("FAIL %s: read @%h got %h expected %h", why, a, reg_rdata, e);
    end
  endtask

  task automatic run(input int n, input logic [3:0] mask, input int mode);
    for (int k = 0; k < n; k++) begin
      logic [3:0] s;
      case (mode)
        0: s = mask;
        1: s = (k % 2 == 0) ? mask : 4'h0;
        default: s = 4'($urandom) & mask;
      endcase
      cycle(1'b0, 4'h0, 32'h0, s);
    end
  endtask

  // Monitor: compare every channel strobe after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [15:0] e;
        e = exp_q.pop_front();
        vectors++;
        if (ch_tick !== e) begin
          miscompares++;
          $display("FAIL %s: ch_tick=%h expected %h", tag, ch_tick, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (ch_tick !== 16'h0) begin
      miscompares++;
      $display("FAIL R1: ch_tick in reset=%h expected 0", ch_tick);
    end
    rst_n = 1'b1;

    // R1: reset values and silence while all channels are held
    tag = "R1";
    rd_check(4'h0, "R1 disable word");
    rd_check(4'h4, "R1 source word");
    rd_check(4'h8, "R1 ratio word");
    run(20, 4'hF, 0);

    // R4/R8/R5: ratios 1,2,4,8 on channels 0..3 from source 0
    tag = "R4";
    wr(4'h8, 32'h0000_00E4, 4'h1);
    wr(4'h0, 32'h0000_FFF0, 4'h1);
    run(60, 4'h1, 0);
    tag = "R8";
    run(60, 4'h1, 1);

    // R3/R9: channels 4..7 each on a different source, ratio 2
    tag = "R3";
    wr(4'h4, 32'h0000_3600, 4'h0);
    wr(4'h8, 32'h0000_55E4, 4'h0);
    wr(4'h0, 32'h0000_FF00, 4'h0);
    run(40, 4'h2, 0);
    run(40, 4'h8, 1);
    tag = "R9";
    run(200, 4'hF, 2);

    // R6: mid-period ratio change on channel 3, source change on channel 0
    tag = "R6";
    run(3, 4'h1, 0);
    wr(4'h8, 32'h0000_5524, 4'h1);
    run(30, 4'h1, 1);
    wr(4'h4, 32'h0000_3602, 4'h3);
    run(200, 4'hF, 2);

    // R2: hold channels 0 and 4 off
    tag = "R2";
    wr(4'h0, 32'h0000_FF11, 4'hF);
    run(100, 4'hF, 2);

    // R5: release restarts the count
    tag = "R5";
    run(2, 4'hF, 0);
    wr(4'h0, 32'h0000_FF00, 4'hF);
    run(50, 4'hF, 2);
    wr(4'h0, 32'h0000_FF02, 4'h1);
    run(5, 4'h1, 0);
    wr(4'h0, 32'h0000_FF00, 4'h1);
    run(30, 4'h1, 0);

    // R9: all channels live with scattered programming
    tag = "R9";
    wr(4'h4, $urandom, 4'h0);
    wr(4'h8, $urandom, 4'h0);
    wr(4'h0, 32'h0000_0000, 4'h0);
    run(600, 4'hF, 2);
    wr(4'h8, $urandom, 4'hF);
    run(400, 4'hF, 2);

    // R7: read-back and unmapped offsets
    tag = "R7";
    rd_check(4'h0, "R7 disable word");
    rd_check(4'h4, "R7 source word");
    rd_check(4'h8, "R7 ratio word");
    wr(4'hC, 32'hFFFF_FFFF, 4'h0);
    wr(4'h2, 32'hFFFF_FFFF, 4'h0);
    rd_check(4'hC, "R7 unmapped offset");
    rd_check(4'h0, "R7 disable after unmapped write");
    rd_check(4'h4, "R7 source after unmapped write");
    rd_check(4'h8, "R7 ratio after unmapped write");
    wr(4'h0, 32'hABCD_5A5A, 4'h0);
    rd_check(4'h0, "R7 upper disable bits zero");
    run(100, 4'hF, 2);

    run(4, 4'h0, 0);
    @(negedge clk);
    finish_run();
  end

endmodule